// File: doc/BRIEF.md
# Power-On Strap Capture and Frequency Selector

This block sits in a clock generator's control logic. While the chip powers up, a small group of shared pins carries configuration straps instead of clocks. After power-on reset has ended, the block waits for the active-low power-good input to qualify the straps. It then records their levels once in a 5-bit latch and, one clock later, enables the pins' clock drivers.

From then on, the block chooses the frequency-select code. The code comes either from the latched straps or from a configuration register, as a source-select bit decides. The block decodes the chosen code, through one of two mapping tables, into a CPU frequency index with a reserved flag. It also produces the CPU/PCI spread enable, the SRC spread enable and the SRC overclock step.

A latched test strap raises a sticky test-mode flag. Only the synchronous reset, which models a full power cycle, clears that flag.

Top module: `strap_freq_sel`

## Requirements
- R1: The strap latch is written exactly once after each reset: at the first rising edge with `rst` low and `pwrgd_n` low. Later changes on `strap_in` or `pwrgd_n` leave the latch and every output derived from it unchanged. Strap bit order: [2:0] = frequency code (bit 2 most significant), [3] = table select, [4] = test.
- R2: `pin_oe` is all zeros until the capture edge and at that edge. It becomes all ones at the following edge.
- R3: `cfg_fsel[7]` = 0 takes the code and the table bit from the latch. `cfg_fsel[7]` = 1 takes the code from `cfg_fsel[2:0]` and the table bit from `cfg_fsel[4]`. `fs_code` = {table, code}.
- R4: The frequency index encoding is 0=100, 1=133.33, 2=166.67, 3=200, 4=266.67, 5=333.33, 6=400 MHz, and 7=reserved. With table 0, codes 0..7 give 266.67, 133.33, 200, 166.67, 333.33, 100, 400 MHz and reserved.
- R5: With table 1, codes 0..7 give 100, 133.33, 200, 166.67, 200, 266.67, 400 and 333.33 MHz.
- R6: `cpu_reserved` is 1 exactly when the index is 7, which happens only for table 0, code 7.
- R7: `cpu_spread_en` = `cfg_fsel[6]` AND `cfg_fsel[3]`.
- R8: `src_spread_en` = `cfg_src[4]`. `src_ovc_pct` is 0, 1, 2 or 4 for `cfg_src[3:2]` = 0, 1, 2 or 3. `cfg_src[1:0]` and `cfg_src[7:5]` have no effect.
- R9: `test_mode` rises at the capture edge if strap bit 4 was 1. It then stays 1 until reset.
- R10: While `rst` is high, every output is 0 and the latch holds zeros, matching undriven strap pins.
- R11: `fs_code`, `cpu_freq_idx`, `cpu_reserved`, `cpu_spread_en`, `src_spread_en` and `src_ovc_pct` are registered. Each follows its inputs one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power cycle) |
| pwrgd_n | input | 1 | Active-low power-good; qualifies the straps |
| strap_in | input | 5 | Strap levels on the shared pins |
| cfg_fsel | input | 8 | Frequency-select configuration register |
| cfg_src | input | 8 | SRC control configuration register |
| pin_oe | output | 5 | Clock driver enables for the shared pins |
| fs_code | output | 4 | Effective {table, code} |
| cpu_freq_idx | output | 3 | Decoded CPU frequency index |
| cpu_reserved | output | 1 | Selected code is reserved |
| cpu_spread_en | output | 1 | CPU/PCI spread enable |
| src_spread_en | output | 1 | SRC spread enable |
| src_ovc_pct | output | 3 | SRC overclock in percent |
| test_mode | output | 1 | Sticky test mode flag |

## Verification
The capture happens at the first edge that sees `pwrgd_n` low after reset, and `test_mode` changes at that same edge. `pin_oe` and the strap-derived decode outputs follow one edge later. Register-driven outputs change one edge after the register input changes.

The bench drives every input on a falling edge and checks on the next falling edge, after exactly the number of rising edges stated for each result. It therefore checks `pin_oe` both at the capture edge and one edge after it. It sweeps every register value and every strap combination.

// File: rtl/strap_pkg.sv
package strap_pkg;
  typedef enum logic [2:0] {
    FQ_100 = 3'd0, FQ_133 = 3'd1, FQ_167 = 3'd2, FQ_200 = 3'd3,
    FQ_267 = 3'd4, FQ_333 = 3'd5, FQ_400 = 3'd6, FQ_RSV = 3'd7
  } freq_e;

  function automatic freq_e map_code(input logic tbl, input logic [2:0] code);
    freq_e f;
    if (!tbl) begin
      case (code)
        3'd0: f = FQ_267;
        3'd1: f = FQ_133;
        3'd2: f = FQ_200;
        3'd3: f = FQ_167;
        3'd4: f = FQ_333;
        3'd5: f = FQ_100;
        3'd6: f = FQ_400;
        default: f = FQ_RSV;
      endcase
    end else begin
      case (code)
        3'd0: f = FQ_100;
        3'd1: f = FQ_133;
        3'd2: f = FQ_200;
        3'd3: f = FQ_167;
        3'd4: f = FQ_200;
        3'd5: f = FQ_267;
        3'd6: f = FQ_400;
        default: f = FQ_333;
      endcase
    end
    return f;
  endfunction
endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int STRAP_W  = 5,
  parameter int TEST_BIT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwrgd_n,
  input  logic [STRAP_W-1:0] strap_in,
  output logic [STRAP_W-1:0] strap_q,
  output logic               captured,
  output logic [STRAP_W-1:0] pin_oe,
  output logic               test_mode
);
  logic take;
  assign take = !captured && !pwrgd_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      strap_q   <= '0;
      captured  <= 1'b0;
      test_mode <= 1'b0;
    end else if (take) begin
      strap_q   <= strap_in;
      captured  <= 1'b1;
      test_mode <= test_mode | strap_in[TEST_BIT];
    end
  end

  for (genvar i = 0; i < STRAP_W; i++) begin : g_oe
    always_ff @(posedge clk) begin
      if (rst) pin_oe[i] <= 1'b0;
      else     pin_oe[i] <= captured;
    end
  end

  // R1
  latch_once_chk: assert property (@(posedge clk) disable iff (rst)
    $past(captured) |-> $stable(strap_q));
  // R2
  oe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(captured) |-> (pin_oe == '0));
  // R9
  test_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(test_mode) |-> test_mode);
endmodule

// File: rtl/freq_decode.sv
module freq_decode
  import strap_pkg::*;
#(
  parameter int STRAP_W = 5,
  parameter int FS_W    = 3,
  parameter int REG_W   = 8,
  parameter int OVC_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] strap_q,
  input  logic [REG_W-1:0]   cfg_fsel,
  input  logic [REG_W-1:0]   cfg_src,
  output logic [FS_W:0]      fs_code,
  output logic [2:0]         cpu_freq_idx,
  output logic               cpu_reserved,
  output logic               cpu_spread_en,
  output logic               src_spread_en,
  output logic [OVC_W-1:0]   src_ovc_pct
);
  localparam int SRC_SEL_BIT = 7;
  localparam int SS_A_BIT    = 6;
  localparam int TBL_BIT     = 4;
  localparam int SS_B_BIT    = 3;
  localparam int SRC_SS_BIT  = 4;
  localparam int OVC_LO      = 2;

  logic [FS_W-1:0] code_sel;
  logic            tbl_sel;
  freq_e           f_sel;
  logic [1:0]      ovc_sel;
  logic [OVC_W-1:0] ovc_pct;

  always_comb begin
    if (cfg_fsel[SRC_SEL_BIT]) begin
      code_sel = cfg_fsel[FS_W-1:0];
      tbl_sel  = cfg_fsel[TBL_BIT];
    end else begin
      code_sel = strap_q[FS_W-1:0];
      tbl_sel  = strap_q[FS_W];
    end
    f_sel   = map_code(tbl_sel, code_sel);
    ovc_sel = cfg_src[OVC_LO+1:OVC_LO];
    ovc_pct = (ovc_sel == 2'd0) ? '0 : OVC_W'(1 << (ovc_sel - 2'd1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_code       <= '0;
      cpu_freq_idx  <= '0;
      cpu_reserved  <= 1'b0;
      cpu_spread_en <= 1'b0;
      src_spread_en <= 1'b0;
      src_ovc_pct   <= '0;
    end else begin
      fs_code       <= {tbl_sel, code_sel};
      cpu_freq_idx  <= f_sel;
      cpu_reserved  <= (f_sel == FQ_RSV);
      cpu_spread_en <= cfg_fsel[SS_A_BIT] & cfg_fsel[SS_B_BIT];
      src_spread_en <= cfg_src[SRC_SS_BIT];
      src_ovc_pct   <= ovc_pct;
    end
  end

  // R7
  cpu_ss_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_spread_en |-> ($past(cfg_fsel[SS_A_BIT]) && $past(cfg_fsel[SS_B_BIT])));
  // R8
  src_ovc_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_ovc_pct));
  // R6
  rsv_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_reserved |-> (fs_code == {1'b0, {FS_W{1'b1}}}));
endmodule

// File: rtl/strap_freq_sel.sv
module strap_freq_sel #(
  parameter int STRAP_W  = 5,
  parameter int FS_W     = 3,
  parameter int REG_W    = 8,
  parameter int OVC_W    = 3,
  parameter int TEST_BIT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwrgd_n,
  input  logic [STRAP_W-1:0] strap_in,
  input  logic [REG_W-1:0]   cfg_fsel,
  input  logic [REG_W-1:0]   cfg_src,
  output logic [STRAP_W-1:0] pin_oe,
  output logic [FS_W:0]      fs_code,
  output logic [2:0]         cpu_freq_idx,
  output logic               cpu_reserved,
  output logic               cpu_spread_en,
  output logic               src_spread_en,
  output logic [OVC_W-1:0]   src_ovc_pct,
  output logic               test_mode
);
  logic [STRAP_W-1:0] strap_q;
  logic               captured;

  strap_capture #(.STRAP_W(STRAP_W), .TEST_BIT(TEST_BIT)) u_cap (
    .clk(clk), .rst(rst), .pwrgd_n(pwrgd_n), .strap_in(strap_in),
    .strap_q(strap_q), .captured(captured), .pin_oe(pin_oe),
    .test_mode(test_mode)
  );

  freq_decode #(.STRAP_W(STRAP_W), .FS_W(FS_W), .REG_W(REG_W), .OVC_W(OVC_W)) u_dec (
    .clk(clk), .rst(rst), .strap_q(strap_q), .cfg_fsel(cfg_fsel),
    .cfg_src(cfg_src), .fs_code(fs_code), .cpu_freq_idx(cpu_freq_idx),
    .cpu_reserved(cpu_reserved), .cpu_spread_en(cpu_spread_en),
    .src_spread_en(src_spread_en), .src_ovc_pct(src_ovc_pct)
  );

  // R2
  oe_after_pg_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_oe != '0) |-> (pin_oe == '1));
endmodule

// File: tb/strap_freq_sel_test.sv
module strap_freq_sel_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwrgd_n = 1'b1;
  logic [4:0] strap_in = '0;
  logic [7:0] cfg_fsel = '0;
  logic [7:0] cfg_src = '0;
  logic [4:0] pin_oe;
  logic [3:0] fs_code;
  logic [2:0] cpu_freq_idx;
  logic       cpu_reserved, cpu_spread_en, src_spread_en, test_mode;
  logic [2:0] src_ovc_pct;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  strap_freq_sel uut (
    .clk(clk), .rst(rst), .pwrgd_n(pwrgd_n), .strap_in(strap_in),
    .cfg_fsel(cfg_fsel), .cfg_src(cfg_src), .pin_oe(pin_oe),
    .fs_code(fs_code), .cpu_freq_idx(cpu_freq_idx),
    .cpu_reserved(cpu_reserved), .cpu_spread_en(cpu_spread_en),
    .src_spread_en(src_spread_en), .src_ovc_pct(src_ovc_pct),
    .test_mode(test_mode)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // frequency in units of 10 kHz, 0 = reserved
  function automatic int mhz_of(input int tbl, input int code);
    int t0[8] = '{26667, 13333, 20000, 16667, 33333, 10000, 40000, 0};
    int t1[8] = '{10000, 13333, 20000, 16667, 20000, 26667, 40000, 33333};
    return tbl ? t1[code] : t0[code];
  endfunction

  function automatic int idx_of(input int f);
    case (f)
      10000: return 0;
      13333: return 1;
      16667: return 2;
      20000: return 3;
      26667: return 4;
      33333: return 5;
      40000: return 6;
      default: return 7;
    endcase
  endfunction

  task automatic check_decode(input string req, input int tbl, input int code);
    int e;
    e = idx_of(mhz_of(tbl, code));
    check({req, " fs_code"}, fs_code, tbl * 8 + code);
    check({req, " freq_idx"}, cpu_freq_idx, e);
    check("R6 reserved", cpu_reserved, (e == 7) ? 1 : 0);
  endtask

  task automatic power_up(input logic [4:0] s, input int wait_cyc);
    @(negedge clk);
    rst = 1'b1; strap_in = s; pwrgd_n = 1'b1; cfg_fsel = '0; cfg_src = '0;
    repeat (2) @(negedge clk);
    check("R10 oe reset", pin_oe, 0);
    check("R10 test reset", test_mode, 0);
    check("R10 fs reset", fs_code, 0);
    rst = 1'b0;
    for (int k = 0; k < wait_cyc; k++) begin
      @(negedge clk);
      check("R2 oe before power-good", pin_oe, 0);
    end
    pwrgd_n = 1'b0;
    @(negedge clk);
    check("R2 oe at capture edge", pin_oe, 0);
    check("R9 test latched", test_mode, s[4]);
    @(negedge clk);
    check("R2 oe after capture", pin_oe, 31);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // strap sweep: every table, code and test value
    for (int s = 0; s < 32; s++) begin
      power_up(5'(s), s % 3);
      check_decode((s[3] ? "R5 strap" : "R4 strap"), s[3], s[2:0]);
      // R1: later pin and power-good changes are ignored
      strap_in = ~5'(s); pwrgd_n = 1'b1;
      repeat (2) @(negedge clk);
      pwrgd_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 latch held", fs_code, s[3:0]);
      check("R1 test held", test_mode, s[4]);
      check("R9 test sticky", test_mode, s[4]);
    end

    // register source sweep
    power_up(5'b10110, 0);
    for (int v = 0; v < 256; v++) begin
      cfg_fsel = 8'(v);
      @(negedge clk);
      if (v[7]) check_decode("R3 reg source", v[4], v[2:0]);
      else      check_decode("R3 strap source", 0, 6);
      check("R7 cpu spread", cpu_spread_en, v[6] & v[3]);
      check("R11 one-cycle", fs_code, v[7] ? {v[4], v[2:0]} : 4'b0110);
    end

    // SRC control sweep
    for (int v = 0; v < 256; v++) begin
      int ep;
      cfg_src = 8'(v);
      @(negedge clk);
      case (v[3:2])
        0: ep = 0;
        1: ep = 1;
        2: ep = 2;
        default: ep = 4;
      endcase
      check("R8 src spread", src_spread_en, v[4]);
      check("R8 src ovc", src_ovc_pct, ep);
    end
    check("R9 test survives registers", test_mode, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule